// File: doc/BRIEF.md
# SPI Word Master with Byte Reorder and Byte Gap

This block is the transmit and receive engine of an SPI master. A start pulse sends one word from `tx_word` out on MOSI and shifts in the same number of bits from MISO. The received word appears on `rx_word` when the transfer finishes. The serial clock idles low. Data leaves on the falling edge and is captured on the rising edge. A single active-low select frames the word.

A 2-bit mode input turns two options on and off independently. The first option reverses the byte order of the word on the wire. The second inserts a programmable idle gap between the bytes of a word. Both options need 32-bit words, which is a length field of zero. The same 4-bit gap value also sets an idle time with select high after each word, before the transfer counts as done.

When the transfer ends, a sticky done flag is set. This flag drives the interrupt output only when the interrupt enable is high. Software clears the flag by writing 1; writing 0 leaves it set. The configuration inputs are captured at the start pulse.

Top module: `spi_word_engine`

## Requirements
- R1: With mode 00 and a length of 0, the 32 bits of `tx_word` go out MSB first. `rx_word` holds the 32 received bits, the first one received in bit 31.
- R2: With mode 10 and a length of 0, the bytes go out in the order byte 0 (bits 7:0), then byte 1, byte 2 and byte 3, each MSB first. The received bytes are placed into `rx_word` in the same order: the first byte received lands in bits 7:0.
- R3: With mode 11 and a length of 0, the byte order is the same as in mode 00, and an idle gap with SCLK low is inserted after bits 8, 16 and 24.
- R4: With mode 01 and a length of 0, the byte order of R2 and the byte gaps of R3 apply together.
- R5: Let G be `cfg_gap` and T one SCLK period. At each inserted byte gap, the rising edges on either side are T*(G+3) apart; every other pair of consecutive rising edges is T apart. The done flag rises G+2 periods after chip select goes high.
- R6: With a nonzero `cfg_len` L, the mode bits have no effect. The low L bits of `tx_word` are sent MSB first with no gaps, and the L received bits fill `rx_word[L-1:0]` with the upper bits zero.
- R7: SCLK is low whenever chip select is high. T equals 2*max(`cfg_div`,1) clock cycles. MOSI changes only while SCLK is low.
- R8: Chip select falls half a period before the first rising edge of SCLK. It stays low through all byte gaps and rises 1.5 periods after the last rising edge.
- R9: Every finished transfer sets `done_flag`. `irq` is high exactly when `done_flag` and `cfg_ie` are both 1.
- R10: A cycle with `flag_wr` high and `flag_wdata` 1 clears `done_flag`. With `flag_wdata` 0 the flag is unchanged.
- R11: A start pulse while `busy` is high is ignored. `busy` stays high from the cycle after an accepted start until the cycle in which `done_flag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to start one word |
| tx_word | input | 32 | Word to transmit |
| cfg_mode | input | 2 | Byte reorder / byte gap select |
| cfg_len | input | LEN_W | Bits per word, 0 means 32 |
| cfg_gap | input | GAP_W | Gap value G, giving G+2 SCLK periods |
| cfg_div | input | DIV_W | Half-period of SCLK in clock cycles (0 acts as 1) |
| cfg_ie | input | 1 | Interrupt enable |
| flag_wr | input | 1 | Write strobe for the done flag |
| flag_wdata | input | 1 | Data written to the done flag; 1 clears |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Sticky transfer-complete flag |
| irq | output | 1 | Interrupt request |
| rx_word | output | 32 | Last word received |

## Verification
The assertions check on every cycle that SCLK stays low while the slave is not selected and that MOSI holds steady while SCLK is high. They also check that the interrupt is masked when the enable is low and is never high without the flag, that the flag survives any cycle without a write of 1, and that busy only drops as the flag rises. The byte order on the wire, the reassembly of received data, the exact gap and select spacings, the fallback for short words and the ignored start pulse depend on whole transfers. Only the bench's scenarios can show these: it times SCLK edges against a scoreboard of expected wire words.

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
  parameter int DIV_W = 8,
  parameter int GAP_W = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      tx_word,
  input  logic [1:0]       cfg_mode,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_ie,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             busy,
  output logic             done_flag,
  output logic             irq,
  output logic [31:0]      rx_word
);
  localparam int BCW = LEN_W + 1;
  localparam int GCW = GAP_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_TAIL, S_WGAP} state_t;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  state_t           st;
  logic [DIV_W-1:0] hcnt, hdiv_r;
  logic [GCW-1:0]   gcnt;
  logic [BCW-1:0]   bits, nbits_r;
  logic [GAP_W-1:0] gap_r;
  logic [31:0]      tx_sr, rx_sr;
  logic             reord_r, susp_r, sclk_r, cs_r, flag_r;

  logic             go, tick, len32, reo, sus, flag_set;
  logic [BCW-1:0]   nb;
  logic [GCW-1:0]   gap_half;

  assign go       = start && (st == S_IDLE);
  assign tick     = (st != S_IDLE) && (hcnt == hdiv_r - 1'b1);
  assign len32    = (cfg_len == '0);
  assign reo      = len32 && (cfg_mode == 2'b01 || cfg_mode == 2'b10);
  assign sus      = len32 && (cfg_mode == 2'b01 || cfg_mode == 2'b11);
  assign nb       = len32 ? BCW'(32) : {1'b0, cfg_len};
  assign gap_half = ({3'b000, gap_r} << 1) + GCW'(3);
  assign flag_set = tick && (st == S_WGAP) && (gcnt == '0);

  assign sclk      = sclk_r;
  assign cs_n      = cs_r;
  assign mosi      = cs_r ? 1'b0 : tx_sr[31];
  assign busy      = (st != S_IDLE);
  assign done_flag = flag_r;
  assign irq       = flag_r && cfg_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt <= '0;
    else if (st == S_IDLE || tick) hcnt <= '0;
    else hcnt <= hcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_r <= 1'b0;
    else if (flag_set) flag_r <= 1'b1;
    else if (flag_wr && flag_wdata) flag_r <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      gcnt    <= '0;
      bits    <= '0;
      nbits_r <= BCW'(32);
      hdiv_r  <= DIV_W'(1);
      gap_r   <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_word <= '0;
      reord_r <= 1'b0;
      susp_r  <= 1'b0;
      sclk_r  <= 1'b0;
      cs_r    <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st      <= S_SHIFT;
          cs_r    <= 1'b0;
          sclk_r  <= 1'b0;
          bits    <= '0;
          nbits_r <= nb;
          gap_r   <= cfg_gap;
          hdiv_r  <= (cfg_div == '0) ? DIV_W'(1) : cfg_div;
          reord_r <= reo;
          susp_r  <= sus;
          rx_sr   <= '0;
          tx_sr   <= (reo ? bswap(tx_word) : tx_word) << (BCW'(32) - nb);
        end
        S_SHIFT: if (tick) begin
          if (!sclk_r) begin
            sclk_r <= 1'b1;
            rx_sr  <= {rx_sr[30:0], miso};
          end else begin
            sclk_r <= 1'b0;
            bits   <= bits + 1'b1;
            tx_sr  <= {tx_sr[30:0], 1'b0};
            if (bits + 1'b1 == nbits_r) begin
              st   <= S_TAIL;
              gcnt <= GCW'(1);
            end else if (susp_r && bits[2:0] == 3'd7) begin
              st   <= S_GAP;
              gcnt <= gap_half;
            end
          end
        end
        S_GAP: if (tick) begin
          if (gcnt == '0) st <= S_SHIFT;
          else gcnt <= gcnt - 1'b1;
        end
        S_TAIL: if (tick) begin
          if (gcnt == '0) begin
            cs_r <= 1'b1;
            st   <= S_WGAP;
            gcnt <= gap_half;
          end else gcnt <= gcnt - 1'b1;
        end
        S_WGAP: if (tick) begin
          if (gcnt == '0) begin
            st      <= S_IDLE;
            rx_word <= reord_r ? bswap(rx_sr) : rx_sr;
          end else gcnt <= gcnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_word_engine_chk.sv
module spi_word_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic busy,
  input logic done_flag,
  input logic irq,
  input logic cfg_ie,
  input logic flag_wr,
  input logic flag_wdata
);
  p_sclk_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_idle_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ie |-> !irq);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !(flag_wr && flag_wdata)) |=> done_flag);

  p_busy_until_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);
endmodule

bind spi_word_engine spi_word_engine_chk u_chk (.*);

// File: tb/sim_spi_word_engine.sv
`timescale 1ns/1ps
module sim_spi_word_engine;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] tx_word = '0;
  logic [1:0]  cfg_mode = '0;
  logic [4:0]  cfg_len = '0;
  logic [3:0]  cfg_gap = '0;
  logic [7:0]  cfg_div = 8'd2;
  logic        cfg_ie = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic        miso, sclk, mosi, cs_n, busy, done_flag, irq;
  logic [31:0] rx_word;

  always #5 clk = ~clk;

  spi_word_engine u0 (.*);

  typedef struct {
    logic [31:0] wire_bits;
    int          nbits;
    int          half;
    int          gap;
    bit          gaps_on;
    string       tag;
  } exp_t;
  exp_t exq[$];

  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic logic [31:0] swap4(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model
  logic [31:0] slave_word = '0, slave_sr = '0;
  assign miso = slave_sr[31];
  always @(negedge cs_n) slave_sr <= slave_word;
  always @(negedge sclk) slave_sr <= {slave_sr[30:0], 1'b0};

  // monitor
  logic [31:0] cap;
  int          nrise;
  realtime     t_csfall, t_csrise, rise_t[64];
  int          cs_falls = 0;
  always @(negedge cs_n) begin
    cap = '0; nrise = 0; t_csfall = $realtime; cs_falls++;
  end
  always @(posedge sclk) begin
    cap = {cap[30:0], mosi};
    if (nrise < 64) rise_t[nrise] = $realtime;
    nrise++;
  end
  always @(posedge cs_n) begin
    if (rst_n) begin
      t_csrise = $realtime;
      if (exq.size() == 0) begin
        check(0, "R11", "unexpected transfer", 0, 1);
      end else begin
        exp_t e;
        int   bad;
        real  p;
        e = exq.pop_front();
        p = 20.0 * e.half;
        check(nrise == e.nbits, e.tag, "bit count", nrise, e.nbits);
        check(cap == e.wire_bits, e.tag, "wire word", cap, e.wire_bits);
        bad = 0;
        for (int i = 1; i < nrise && i < 64; i++) begin
          real want;
          want = (e.gaps_on && (i % 8 == 0)) ? p * (e.gap + 3) : p;
          if (rise_t[i] - rise_t[i-1] != want) bad++;
        end
        check(bad == 0, "R5", {e.tag, " edge spacing"}, bad, 0);
        check(rise_t[0] - t_csfall == p / 2, "R8", "select lead",
              longint'(rise_t[0] - t_csfall), longint'(p / 2));
        check(t_csrise - rise_t[nrise-1] == 1.5 * p, "R8", "select tail",
              longint'(t_csrise - rise_t[nrise-1]), longint'(1.5 * p));
      end
    end
  end

  task automatic run(input logic [1:0] mode, input logic [4:0] len,
                     input logic [3:0] gap, input logic [7:0] div,
                     input logic [31:0] tx, input logic [31:0] sw,
                     input bit ie, input string tag, input bit poke);
    exp_t        e;
    bit          l32, reo, sus;
    logic [31:0] w, rx_exp;
    realtime     t_done;
    l32 = (len == 0);
    reo = l32 && (mode == 2'b01 || mode == 2'b10);
    sus = l32 && (mode == 2'b01 || mode == 2'b11);
    e.nbits   = l32 ? 32 : int'(len);
    e.half    = (div == 0) ? 1 : int'(div);
    e.gap     = int'(gap);
    e.gaps_on = sus;
    e.tag     = tag;
    w = reo ? swap4(tx) : tx;
    e.wire_bits = l32 ? w : (w & ((32'd1 << e.nbits) - 1));
    rx_exp = l32 ? (reo ? swap4(sw) : sw) : (sw >> (32 - e.nbits));
    exq.push_back(e);
    @(negedge clk);
    cfg_mode = mode; cfg_len = len; cfg_gap = gap; cfg_div = div;
    cfg_ie = ie; tx_word = tx; slave_word = sw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      tx_word = ~tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R11", "busy during ignored start", busy, 1);
    end
    @(posedge done_flag);
    t_done = $realtime;
    @(negedge clk);
    check(busy == 1'b0 && done_flag == 1'b1, "R11", "busy low with flag",
          {busy, done_flag}, 2'b01);
    check(t_done - t_csrise == 20.0 * e.half * (e.gap + 2), "R5", "word gap",
          longint'(t_done - t_csrise), longint'(20.0 * e.half * (e.gap + 2)));
    check(rx_word == rx_exp, tag, "rx word", rx_word, rx_exp);
    check(irq == ie, "R9", "irq gating", irq, ie);
    flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk);
    flag_wr = 1'b0;
    @(negedge clk);
    check(done_flag == 1'b1, "R10", "write 0 keeps flag", done_flag, 1);
    flag_wr = 1'b1; flag_wdata = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0; flag_wdata = 1'b0;
    @(negedge clk);
    check(done_flag == 1'b0 && irq == 1'b0, "R10", "write 1 clears flag",
          {done_flag, irq}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1 && sclk == 0, "R7", "reset pins", {cs_n, sclk}, 2'b10);
    check(busy == 0 && done_flag == 0 && irq == 0, "R9", "reset status",
          {busy, done_flag, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(2'b00, 5'd0, 4'd3, 8'd2, 32'hA1B2C3D4, 32'h5A3C96E1, 1, "R1", 0);
    run(2'b10, 5'd0, 4'd1, 8'd2, 32'h12345678, 32'hF00D1234, 1, "R2", 0);
    run(2'b11, 5'd0, 4'd3, 8'd2, 32'h8001FF7E, 32'hC3A50F96, 0, "R3", 0);
    run(2'b01, 5'd0, 4'd15, 8'd3, 32'hDEADBEEF, 32'h0123ABCD, 1, "R4", 0);
    run(2'b01, 5'd0, 4'd0, 8'd0, 32'h5566AA99, 32'h9A7C3E11, 0, "R4", 0);
    run(2'b01, 5'd12, 4'd2, 8'd2, 32'hFFFFF9C5, 32'hB7E10000, 1, "R6", 0);
    run(2'b11, 5'd20, 4'd5, 8'd1, 32'h000ABCDE, 32'h3C5A9000, 0, "R6", 0);
    begin
      int falls0;
      falls0 = cs_falls;
      run(2'b00, 5'd0, 4'd2, 8'd1, 32'h0F1E2D3C, 32'h6B2A1908, 1, "R11", 1);
      repeat (60) @(negedge clk);
      check(cs_falls - falls0 == 1 && cs_n == 1, "R11", "one transfer only",
            cs_falls - falls0, 1);
    end
    check(exq.size() == 0, "R11", "scoreboard drained", exq.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule